// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static Memory Core

This block is a synthesizable, clock-accurate model of a 16-bit-wide static memory whose pins have no clock. It takes a word address, an active-low chip select, an active-low write strobe, an active-low output gate and two active-low byte selects. Write data arrives on its own bus. Read data leaves on a separate bus, together with one drive flag per byte lane, so the flags stand in for the tri-state buffers of a shared bus.

A fast internal clock samples every pin through a two-stage synchronizer. The control logic decodes four states for each byte lane: standby, read, write and output off. A write lands in storage at the trailing (rising) edge of whichever strobe ends it, the write strobe or the chip select. The address, data and lane selects used for that write come from the sample taken just before the edge. Read data is looked up continuously from the sampled address, so the output follows an address change without any control edge.

The storage depth is 2^AddrW words. The default of 11 address bits keeps elaboration small. Setting AddrW to 15 gives the full 32,768-word organisation.

Top module: `bytelane_sram`

## Requirements
- R1: Storage holds 2^AddrW words of 16 bits. Each address keeps its own word, including address 0 and the highest address.
- R2: With chip select high (ceN=1), laneDrive is 2'b00 and dataOut is 0 whatever the other pins do, and no write reaches storage.
- R3: With ceN=0, weN=1 and oeN=0, laneDrive[0] is set when lbN=0 and laneDrive[1] is set when ubN=0. A driven lane shows the stored bits: lane 0 is bits 7:0 and lane 1 is bits 15:8. An undriven lane reads as 0 on dataOut.
- R4: A write updates bits 7:0 only if lbN was low, and bits 15:8 only if ubN was low. An unselected lane keeps its old value, so a write with both selects high changes nothing.
- R5: A write that ends with weN rising while ceN stays low stores the data present before the edge.
- R6: A write that ends with ceN rising while weN is still low also stores its data.
- R7: laneDrive is 2'b00 when oeN is high, when weN is low, or when both byte selects are high.
- R8: The level of oeN has no effect on a write.
- R9: Pin changes reach laneDrive and dataOut after exactly two clock edges. A change of address alone updates dataOut with this latency.
- R10: While rstN is low, laneDrive is 2'b00. Reset clears the sampled pin state but leaves stored words intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal sampling clock |
| rstN | input | 1 | Asynchronous active-low reset of the sampling logic |
| ceN | input | 1 | Active-low chip select |
| weN | input | 1 | Active-low write strobe |
| oeN | input | 1 | Active-low output gate |
| ubN | input | 1 | Active-low select for bits 15:8 |
| lbN | input | 1 | Active-low select for bits 7:0 |
| addr | input | AddrW | Word address |
| dataIn | input | 16 | Write data |
| dataOut | output | 16 | Read data, zero on undriven lanes |
| laneDrive | output | 2 | Per-lane drive flags, bit 0 for bits 7:0 |

## Verification
The bench ends writes both ways: by raising the write strobe while the chip select stays low, and by raising the chip select while the strobe is still low. A model that only watched one strobe would lose half the writes. Partial writes on each lane, and a write with no lane selected, are read back as whole words, which exposes a design that gates the lanes wrongly or merges them. The bench also drives the pins with the write strobe low and both selects high, then returns them to idle. That makes a trailing edge that must store nothing, and must not leave a lane driven. Address tracking is sampled one edge and two edges after the change, which catches an extra or a missing pipeline stage. A reset in the middle of the run must turn the drive flags off and keep the stored words.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int Lanes = 2;

  typedef struct packed {
    logic             commit;
    logic [Lanes-1:0] wrLanes;
    logic [Lanes-1:0] drvLanes;
  } strobe_t;
endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
#(
  parameter int AddrW = 11,
  parameter int DataW = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic             weN,
  input  logic             oeN,
  input  logic [Lanes-1:0] beN,
  input  logic [AddrW-1:0] addr,
  input  logic [DataW-1:0] din,
  output strobe_t          stb,
  output logic [AddrW-1:0] rdAddr,
  output logic [AddrW-1:0] wrAddr,
  output logic [DataW-1:0] wrData
);
  localparam int CtlW = 3 + Lanes;
  localparam int HoldW = 2 + Lanes;

  logic [CtlW-1:0]  ctlS1, ctlS2;
  logic [HoldW-1:0] ctlS3;
  logic [AddrW-1:0] addrS1, addrS2, addrS3;
  logic [DataW-1:0] dataS1, dataS2, dataS3;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlS1 <= '1;
      ctlS2 <= '1;
      ctlS3 <= '1;
    end else begin
      ctlS1 <= {ceN, weN, oeN, beN};
      ctlS2 <= ctlS1;
      ctlS3 <= {ctlS2[CtlW-1], ctlS2[CtlW-2], ctlS2[Lanes-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    addrS1 <= addr;
    addrS2 <= addrS1;
    addrS3 <= addrS2;
    dataS1 <= din;
    dataS2 <= dataS1;
    dataS3 <= dataS2;
  end

  logic ceNow, weNow, oeNow, cePrev, wePrev;
  logic [Lanes-1:0] beNow, bePrev;
  logic writeNow, writePrev, readNow;

  always_comb begin
    ceNow  = ~ctlS2[CtlW-1];
    weNow  = ~ctlS2[CtlW-2];
    oeNow  = ~ctlS2[CtlW-3];
    beNow  = ~ctlS2[Lanes-1:0];
    cePrev = ~ctlS3[HoldW-1];
    wePrev = ~ctlS3[HoldW-2];
    bePrev = ~ctlS3[Lanes-1:0];

    writeNow  = ceNow & weNow;
    writePrev = cePrev & wePrev;
    readNow   = ceNow & ~weNow & oeNow;

    stb.commit   = writePrev & ~writeNow;
    stb.wrLanes  = bePrev & {Lanes{stb.commit}};
    stb.drvLanes = beNow & {Lanes{readNow}};
  end

  assign rdAddr = addrS2;
  assign wrAddr = addrS3;
  assign wrData = dataS3;
endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import sram_pkg::*;
#(
  parameter int AddrW = 11,
  parameter int LaneW = 8
) (
  input  logic                   clk,
  input  strobe_t                stb,
  input  logic [AddrW-1:0]       rdAddr,
  input  logic [AddrW-1:0]       wrAddr,
  input  logic [Lanes*LaneW-1:0] wrData,
  output logic [Lanes*LaneW-1:0] rdData,
  output logic [Lanes-1:0]       laneOn
);
  localparam int DataW = Lanes * LaneW;
  localparam int Depth = 1 << AddrW;

  logic [DataW-1:0] store [Depth];
  logic [DataW-1:0] rdWord;

  always_ff @(posedge clk) begin
    for (int l = 0; l < Lanes; l++) begin
      if (stb.wrLanes[l]) store[wrAddr][l*LaneW +: LaneW] <= wrData[l*LaneW +: LaneW];
    end
  end

  assign rdWord = store[rdAddr];

  for (genvar g = 0; g < Lanes; g++) begin : gLane
    assign rdData[g*LaneW +: LaneW] = stb.drvLanes[g] ? rdWord[g*LaneW +: LaneW] : '0;
  end

  assign laneOn = stb.drvLanes;
endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
  import sram_pkg::*;
#(
  parameter int AddrW = 11,
  parameter int LaneW = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   ceN,
  input  logic                   weN,
  input  logic                   oeN,
  input  logic                   ubN,
  input  logic                   lbN,
  input  logic [AddrW-1:0]       addr,
  input  logic [Lanes*LaneW-1:0] dataIn,
  output logic [Lanes*LaneW-1:0] dataOut,
  output logic [Lanes-1:0]       laneDrive
);
  localparam int DataW = Lanes * LaneW;

  strobe_t          stb;
  logic [AddrW-1:0] rdAddr, wrAddr;
  logic [DataW-1:0] wrData;

  sram_ctrl #(.AddrW(AddrW), .DataW(DataW)) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .beN({ubN, lbN}), .addr(addr), .din(dataIn),
    .stb(stb), .rdAddr(rdAddr), .wrAddr(wrAddr), .wrData(wrData)
  );

  sram_datapath #(.AddrW(AddrW), .LaneW(LaneW)) u_dp (
    .clk(clk), .stb(stb), .rdAddr(rdAddr), .wrAddr(wrAddr),
    .wrData(wrData), .rdData(dataOut), .laneOn(laneDrive)
  );
endmodule

// File: rtl/sram_chk.sv
module sram_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ceN,
  input logic       weN,
  input logic       oeN,
  input logic       ubN,
  input logic       lbN,
  input logic [1:0] laneDrive,
  input logic       commit,
  input logic [1:0] wrLanes
);
  logic [2:0] sinceRst;
  logic       valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 3'd4) sinceRst <= sinceRst + 3'd1;
  end
  assign valid = (sinceRst == 3'd4);

  a_r2_standby_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (valid && $past(ceN, 2)) |-> (laneDrive == 2'b00));
  a_r7_gate_high_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (valid && $past(oeN, 2)) |-> (laneDrive == 2'b00));
  a_r7_write_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !$past(weN, 2)) |-> (laneDrive == 2'b00));
  a_r3_low_lane_read: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !$past(ceN, 2) && $past(weN, 2) && !$past(oeN, 2) && !$past(lbN, 2))
    |-> laneDrive[0]);
  a_r3_high_lane_read: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !$past(ceN, 2) && $past(weN, 2) && !$past(oeN, 2) && !$past(ubN, 2))
    |-> laneDrive[1]);
  a_r5_commit_after_write: assert property (@(posedge clk) disable iff (!rstN)
    (valid && commit) |-> (!$past(ceN, 3) && !$past(weN, 3)));
  a_r4_low_lane_gate: assert property (@(posedge clk) disable iff (!rstN)
    (valid && wrLanes[0]) |-> !$past(lbN, 3));
  a_r4_high_lane_gate: assert property (@(posedge clk) disable iff (!rstN)
    (valid && wrLanes[1]) |-> !$past(ubN, 3));
endmodule

bind bytelane_sram sram_chk u_chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
  .ubN(ubN), .lbN(lbN), .laneDrive(laneDrive),
  .commit(stb.commit), .wrLanes(stb.wrLanes)
);

// File: tb/sim_bytelane_sram.sv
module sim_bytelane_sram;
  localparam int ClkPeriod = 10;
  localparam int AddrW = 11;

  typedef struct packed {
    logic [1:0]       op;
    logic [3:0]       req;
    logic             ceN, weN, oeN, ubN, lbN;
    logic [AddrW-1:0] addr;
    logic [15:0]      data;
    logic [1:0]       expDrv;
    logic [15:0]      expData;
  } vec_t;

  localparam int NumVec = 22;
  localparam vec_t Tbl [NumVec] = '{
    '{2'd0, 4'd5,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 11'd5,    16'hA1B2, 2'b00, 16'h0000},
    '{2'd2, 4'd3,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'd5,    16'h0000, 2'b11, 16'hA1B2},
    '{2'd2, 4'd3,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 11'd5,    16'h0000, 2'b01, 16'h00B2},
    '{2'd2, 4'd3,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 11'd5,    16'h0000, 2'b10, 16'hA100},
    '{2'd1, 4'd8,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 11'd7,    16'h1234, 2'b00, 16'h0000},
    '{2'd2, 4'd6,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'd7,    16'h0000, 2'b11, 16'h1234},
    '{2'd0, 4'd4,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 11'd5,    16'hFFFF, 2'b00, 16'h0000},
    '{2'd2, 4'd4,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'd5,    16'h0000, 2'b11, 16'hA1FF},
    '{2'd1, 4'd4,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 11'd5,    16'h0000, 2'b00, 16'h0000},
    '{2'd2, 4'd4,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'd5,    16'h0000, 2'b11, 16'h00FF},
    '{2'd0, 4'd4,  1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 11'd7,    16'h5555, 2'b00, 16'h0000},
    '{2'd2, 4'd4,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'd7,    16'h0000, 2'b11, 16'h1234},
    '{2'd2, 4'd2,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 11'd7,    16'h9999, 2'b00, 16'h0000},
    '{2'd2, 4'd2,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'd7,    16'h0000, 2'b11, 16'h1234},
    '{2'd2, 4'd7,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11'd7,    16'h0000, 2'b00, 16'h0000},
    '{2'd2, 4'd7,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 11'd7,    16'hEEEE, 2'b00, 16'h0000},
    '{2'd2, 4'd7,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 11'd7,    16'h0000, 2'b00, 16'h0000},
    '{2'd2, 4'd7,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'd7,    16'h0000, 2'b11, 16'h1234},
    '{2'd0, 4'd1,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 11'd0,    16'h0F0F, 2'b00, 16'h0000},
    '{2'd0, 4'd1,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 11'd2047, 16'hF0F0, 2'b00, 16'h0000},
    '{2'd2, 4'd1,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'd0,    16'h0000, 2'b11, 16'h0F0F},
    '{2'd2, 4'd1,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'd2047, 16'h0000, 2'b11, 16'hF0F0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1, ubN = 1'b1, lbN = 1'b1;
  logic [AddrW-1:0] addr = '0;
  logic [15:0] dataIn = '0;
  logic [15:0] dataOut;
  logic [1:0]  laneDrive;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(ClkPeriod / 2) clk = ~clk;

  bytelane_sram #(.AddrW(AddrW), .LaneW(8)) u0 (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .ubN(ubN), .lbN(lbN), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .laneDrive(laneDrive)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic goIdle();
    ceN = 1'b1; weN = 1'b1; oeN = 1'b1; ubN = 1'b1; lbN = 1'b1;
  endtask

  task automatic check(input int req, input logic [1:0] expDrv, input logic [15:0] expData);
    total++;
    if (laneDrive !== expDrv || dataOut !== expData) begin
      bad++;
      $display("FAIL R%0d: drive=%b data=%h expected drive=%b data=%h",
               req, laneDrive, dataOut, expDrv, expData);
    end
  endtask

  task automatic runVec(input vec_t v);
    addr = v.addr; dataIn = v.data; ubN = v.ubN; lbN = v.lbN; oeN = v.oeN;
    if (v.op == 2'd2) begin
      ceN = v.ceN; weN = v.weN;
      tick(4);
      check(int'(v.req), v.expDrv, v.expData);
    end else begin
      ceN = 1'b0; weN = 1'b0;
      tick(4);
      if (v.op == 2'd0) begin
        weN = 1'b1; tick(4); ceN = 1'b1;
      end else begin
        ceN = 1'b1; tick(4); weN = 1'b1;
      end
      tick(4);
    end
    goIdle();
    tick(4);
  endtask

  initial begin
    // R10: pins show a read while reset is held, yet nothing drives
    ceN = 1'b0; weN = 1'b1; oeN = 1'b0; ubN = 1'b0; lbN = 1'b0;
    tick(3);
    check(10, 2'b00, 16'h0000);
    goIdle();
    tick(2);
    rstN = 1'b1;
    tick(4);
    check(10, 2'b00, 16'h0000);

    // R1 R2 R3 R4 R5 R6 R7 R8 through the vector table
    for (int i = 0; i < NumVec; i++) runVec(Tbl[i]);

    // R9: address alone moves the output, two edges later
    addr = 11'd5; ceN = 1'b0; weN = 1'b1; oeN = 1'b0; ubN = 1'b0; lbN = 1'b0;
    tick(4);
    check(9, 2'b11, 16'h00FF);
    addr = 11'd7;
    tick(1);
    check(9, 2'b11, 16'h00FF);
    tick(1);
    check(9, 2'b11, 16'h1234);

    // R10: reset mid-run silences lanes and keeps storage
    rstN = 1'b0;
    #1;
    check(10, 2'b00, 16'h0000);
    tick(2);
    rstN = 1'b1;
    tick(4);
    check(10, 2'b11, 16'h1234);
    goIdle();
    tick(4);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(ClkPeriod * 20000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R10: watchdog expired, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule